// File: doc/BRIEF.md
# Integer Second-Order Bandpass Recursive Section

This block is a second-order recursive bandpass filter for 8-bit unsigned sample streams. Every coefficient is a small integer, so the datapath uses only adders, subtractors and shifts. The recurrence is y(n) = (x(n) - x(n-2) - 2*y(n-2)) / 4. The terms in x(n-1) and y(n-1) have zero weight, and the divide by four is an arithmetic shift right by two.

The result can be negative, and so can the partial sum of x(n-2) and 2*y(n-2). Both are therefore carried as signed values. Each past output is stored as a sign flag together with a magnitude, and the flag moves with its value down the history. Before a result leaves the block, a constant bias is added to it and the sum is clamped to 0..255. The output code can then drive a unipolar 8-bit converter directly.

A sample enters on a one-cycle strobe. Two clock edges later, exactly one output-valid pulse carries the code for that sample. When no strobe is present, nothing inside the block moves.

Top module: `bpf_section`

## Requirements
- R1: While synchronous reset is high, out_valid is 0 and out_code is 0. Reset clears every stored past input and output to zero.
- R2: After reset, the first two outputs are floor(x(0)/4) + 128 and floor(x(1)/4) + 128, because all past terms start at zero.
- R3: For every accepted sample, out_code = clamp(floor((x(n) - x(n-2) - 2*y(n-2)) / 4) + 128, 0, 255), where y is the unbiased signed result. Samples x(n-1) and results y(n-1) have no effect.
- R4: The divide by four rounds toward negative infinity. For example, an internal sum of -1 gives y = -1, which is code 127.
- R5: The bias is 128 (parameter BIAS). Each unbiased result is shifted up by the bias and clamped to 0..255, so the code is never negative. A zero result gives code 128.
- R6: Each strobe sampled at a rising edge produces exactly one out_valid pulse, one cycle wide, visible after the second following rising edge. out_valid is never high otherwise.
- R7: In a cycle without a strobe, the stored history and out_code do not change. A stream with idle gaps gives the same codes as the same stream sent back to back.
- R8: Strobes may arrive on consecutive cycles, and every one of them produces its own correct output.
- R9: Negative results keep their sign in the history. The sequence 255, 0, 0, 0, 0 gives codes 191, 128, 32, 128, 176. A stored zero is never flagged negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_data | input | 8 | Unsigned input sample |
| out_valid | output | 1 | One-cycle pulse marking a new output code |
| out_code | output | 8 | Biased, clamped unsigned output code |

## Verification
The code for a strobe sampled at rising edge k is due after edge k+2. The bench stamps each expected code with that cycle number and compares it at the falling edge of that cycle. In every other cycle it requires out_valid to be low. Expected codes come from an integer model of the recurrence in the bench, using floor division and clamping. Hand-computed sequences pin down the floor rounding and the handling of negative history. An exhaustive sweep over the first sample checks the start-up outputs, and long streams, sent both back to back and with idle gaps, check the steady recurrence.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
    parameter int SAMPLE_W = 8;
    parameter int ACC_W    = SAMPLE_W + 3;
    parameter int MAG_W    = ACC_W - 1;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    // stored past output: separate sign flag and magnitude
    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } smag_t;

    function automatic acc_t smag_to_acc(smag_t s);
        acc_t m;
        m = acc_t'({1'b0, s.mag});
        return s.neg ? -m : m;
    endfunction

    function automatic smag_t acc_to_smag(acc_t a);
        smag_t s;
        acc_t  m;
        s.neg = a[ACC_W-1];
        m     = s.neg ? -a : a;
        s.mag = m[MAG_W-1:0];
        return s;
    endfunction

    function automatic acc_t widen(sample_t x);
        return acc_t'({{(ACC_W-SAMPLE_W){1'b0}}, x});
    endfunction
endpackage

// File: rtl/bpf_history.sv
module bpf_history
    import bpf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    shift_en,
    input  sample_t x_in,
    input  smag_t   y_in,
    output sample_t x_old,
    output smag_t   y_old
);
    typedef struct packed {
        sample_t [DEPTH-1:0] x;
        smag_t   [DEPTH-1:0] y;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (shift_en) begin
            h_d.x[0] = x_in;
            h_d.y[0] = y_in;
            for (int i = 1; i < DEPTH; i++) begin
                h_d.x[i] = h_q.x[i-1];
                h_d.y[i] = h_q.y[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) h_q <= '0;
        else     h_q <= h_d;
    end

    assign x_old = h_q.x[DEPTH-1];
    assign y_old = h_q.y[DEPTH-1];
endmodule

// File: rtl/bpf_recur.sv
module bpf_recur
    import bpf_pkg::*;
#(
    parameter int SHIFT = 2,
    parameter int FB_SH = 1
) (
    input  sample_t x_now,
    input  sample_t x_old,
    input  smag_t   y_old,
    output acc_t    y_acc,
    output smag_t   y_sm
);
    acc_t fb, inter, diff;

    always_comb begin
        fb    = smag_to_acc(y_old) <<< FB_SH;   // 2*y(n-2), signed
        inter = widen(x_old) + fb;              // may be negative
        diff  = widen(x_now) - inter;
        y_acc = diff >>> SHIFT;                 // floor division
        y_sm  = acc_to_smag(y_acc);
    end
endmodule

// File: rtl/bpf_bias_sat.sv
module bpf_bias_sat
    import bpf_pkg::*;
#(
    parameter int BIAS = 128
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    y_valid,
    input  acc_t    y_in,
    output logic    out_valid,
    output sample_t out_code
);
    localparam acc_t CODE_MAX = acc_t'((1 << SAMPLE_W) - 1);

    typedef struct packed {
        logic    vld;
        sample_t code;
    } out_t;

    out_t o_d, o_q;
    acc_t sum;

    always_comb begin
        o_d     = o_q;
        sum     = y_in + acc_t'(BIAS);
        o_d.vld = y_valid;
        if (y_valid) begin
            if (sum < 0)             o_d.code = '0;
            else if (sum > CODE_MAX) o_d.code = '1;
            else                     o_d.code = sum[SAMPLE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_code  = o_q.code;
endmodule

// File: rtl/bpf_section.sv
module bpf_section
    import bpf_pkg::*;
#(
    parameter int BIAS = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       out_valid,
    output logic [7:0] out_code
);
    typedef struct packed {
        logic vld;
        acc_t y;
    } stg_t;

    sample_t x_old;
    smag_t   y_old;
    acc_t    y_acc;
    smag_t   y_sm;
    stg_t    s_d, s_q;

    bpf_history #(.DEPTH(2)) i_hist (
        .clk     (clk),
        .rst     (rst),
        .shift_en(in_valid),
        .x_in    (in_data),
        .y_in    (y_sm),
        .x_old   (x_old),
        .y_old   (y_old)
    );

    bpf_recur #(.SHIFT(2), .FB_SH(1)) i_recur (
        .x_now(in_data),
        .x_old(x_old),
        .y_old(y_old),
        .y_acc(y_acc),
        .y_sm (y_sm)
    );

    always_comb begin
        s_d     = s_q;
        s_d.vld = in_valid;
        if (in_valid) s_d.y = y_acc;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    bpf_bias_sat #(.BIAS(BIAS)) i_out (
        .clk      (clk),
        .rst      (rst),
        .y_valid  (s_q.vld),
        .y_in     (s_q.y),
        .out_valid(out_valid),
        .out_code (out_code)
    );
endmodule

// File: rtl/bpf_section_chk.sv
module bpf_section_chk
    import bpf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       out_valid,
    input logic [7:0] out_code,
    input smag_t      y_old
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_code == 8'd0));

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_code));

    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(y_old));

    assert_no_neg_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (y_old.mag == '0) |-> !y_old.neg);
endmodule

bind bpf_section bpf_section_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_code (out_code),
    .y_old    (y_old)
);

// File: tb/test_bpf_section.sv
module test_bpf_section;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       out_valid;
    logic [7:0] out_code;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";
    int    exp_q[$];
    int    due_q[$];
    int    mx1, mx2, my1, my2;
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;   // 125 MHz

    bpf_section i_bpf_section (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_code (out_code)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, bit ok, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // reference: floor((x - x2 - 2*y2)/4) + 128, clamped
    function automatic int model(int x);
        int a, y, c;
        a = x - mx2 - 2 * my2;
        y = (a >= 0) ? a / 4 : -((-a + 3) / 4);
        mx2 = mx1; mx1 = x;
        my2 = my1; my1 = y;
        c = y + 128;
        if (c < 0)   c = 0;
        if (c > 255) c = 255;
        return c;
    endfunction

    // output monitor: code due two edges after the strobe (R6)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                chk({cur_req, " valid"}, out_valid == 1'b1, int'(out_valid), 1);
                chk(cur_req, out_code == exp_q[0][7:0], int'(out_code), exp_q[0]);
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
            end else if (out_valid) begin
                chk("R6 spurious valid", 1'b0, 1, 0);
            end
        end
    end

    task automatic send(int x);
        in_valid = 1'b1;
        in_data  = x[7:0];
        exp_q.push_back(model(x));
        due_q.push_back(cyc + 2);
        @(negedge clk);
    endtask

    task automatic send_lit(int x, int lit);
        int unused;
        in_valid = 1'b1;
        in_data  = x[7:0];
        unused   = model(x);
        exp_q.push_back(lit);
        due_q.push_back(cyc + 2);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", out_valid == 1'b0, int'(out_valid), 0);
        chk("R1 out_code", out_code == 8'd0, int'(out_code), 0);
        rst = 1'b0;
    endtask

    function automatic int next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'(seed[23:16]);
    endfunction

    initial begin
        @(negedge clk);
        cur_req = "R1";
        do_reset();

        // R2: exhaustive first sample, second sample complement
        cur_req = "R2";
        for (int v = 0; v < 256; v++) begin
            do_reset();
            send(v);
            send(255 - v);
            idle(4);
        end

        // R4: floor rounding of a negative sum -1 -> code 127
        cur_req = "R4";
        do_reset();
        send_lit(1, 128);
        send_lit(0, 128);
        send_lit(0, 127);
        idle(4);

        // R9: negative value travels through the history
        cur_req = "R9";
        do_reset();
        send_lit(255, 191);
        send_lit(0, 128);
        send_lit(0, 32);
        send_lit(0, 128);
        send_lit(0, 176);
        idle(4);

        // R5: zero input gives bias code; extreme swings stay in range
        cur_req = "R5";
        do_reset();
        send_lit(0, 128);
        for (int i = 0; i < 64; i++) send(((i / 2) % 2 == 0) ? 255 : 0);
        idle(4);

        // R3 / R8: long back-to-back stream
        cur_req = "R8";
        do_reset();
        for (int i = 0; i < 3000; i++) send(next_rand());
        idle(4);

        // R3 / R7: stream with idle gaps, same model as back to back
        cur_req = "R7";
        do_reset();
        for (int i = 0; i < 1500; i++) begin
            send(next_rand());
            idle(next_rand() % 4);
        end
        idle(4);

        // R7: code holds while idle
        begin
            logic [7:0] held;
            held = out_code;
            for (int i = 0; i < 20; i++) begin
                chk("R7 hold", out_code == held && !out_valid, int'(out_code), int'(held));
                @(negedge clk);
            end
        end

        // R3: sparse-vs-dense equivalence tail
        cur_req = "R3";
        do_reset();
        for (int i = 0; i < 500; i++) send(next_rand() & 8'hF0);
        idle(4);

        chk("R6 drained", exp_q.size() == 0, exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule